// File: doc/BRIEF.md
# Real-Time Clock Calendar Counter with Alarm Match

This block holds a wall-clock time and calendar (seconds, minutes, hours, weekday, date, month, two-digit year) plus a three-field alarm, all as byte registers. A one-cycle pulse on `tick_1hz` starts an update. The time advances by one second, with carries through the whole calendar. The fields are kept either in packed decimal (BCD) or in plain binary, and the hour is held either as 0-23 or as 1-12 with a PM flag in bit 7. Both choices come from a configuration register, and existing contents are never converted when they change.

Software reaches the registers through two steps. A strobe on `idx_we` loads a register index from `wdata[3:0]`. After that, `data_we` writes `wdata` into the indexed register, and `rdata` always shows the indexed register. A sequencer with four states (IDLE, ARMED, STEP, FINISH) raises an update-busy flag for a fixed number of clocks before the increment, so software can tell when a read would be unsafe. A freeze bit blocks updates while software loads a new time. When the busy flag drops, the block emits an update-done pulse. An alarm pulse goes out at the same moment if the new time matches the alarm registers.

Sequencer transitions: IDLE→ARMED on a tick while the freeze bit is clear. ARMED→STEP after `UIP_LEAD` cycles. STEP→FINISH when the freeze bit is clear, which applies the increment. STEP→IDLE when the freeze bit is set, so no increment is applied. FINISH→IDLE always.

Top module: `rtc_tod_core`

## Requirements
- R1: Register map by index: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 weekday, 7 date, 8 month, 9 year, 10 control A, 11 control B, 12 control C, 13 control D. A `data_we` writes `wdata` to the index last loaded by `idx_we`, and `rdata` shows that register in the next cycle.
- R2: After reset, indices 0-9 read 0 except weekday, date and month, which read 0x01. Control A reads 0x00 and control B reads 0x02.
- R3: A tick taken in IDLE while the freeze bit is clear raises `uip_o` (and control A bit 7) from the next cycle for exactly `UIP_LEAD`+1 cycles. The new time is visible in the cycle where `uip_o` falls.
- R4: `upd_done_o` is high for exactly the one cycle in which `uip_o` falls after an applied update.
- R5: Seconds and minutes count 0-59. Wrapping from 59 to 0 carries into the next field.
- R6: With control B bit 1 set (24-hour), the hour counts 0-23, and 23→0 carries into the date and weekday.
- R7: With control B bit 1 clear (12-hour), the hour holds 1-12 with bit 7 = PM. 11 AM→12 PM (0x92 in BCD), 12→1 keeps the PM flag, and 11 PM→12 AM (0x12 in BCD) carries into the date.
- R8: Control B bit 2 set selects binary coding. Clear selects BCD, with the tens in bits 7:4 and the units in bits 3:0.
- R9: The weekday counts 1-7 (7→1). The date wraps to 1 after 30 in April, June, September and November, after 29 in February of a year divisible by 4, after 28 in other Februaries, and after 31 otherwise. The month wraps 12→1 and carries into the year. The year wraps 99→0.
- R10: While control B bit 7 (freeze) is set, a tick does not raise `uip_o` and the time is unchanged, but software writes still take effect.
- R11: Control A bit 7 is read-only status, and writes store only bits 6:0. Control C reads 0x00, control D reads 0x80, and indices 14-15 read 0x00.
- R12: Changing the coding or hour-format bits leaves the stored register values untouched.
- R13: `alarm_o` pulses together with `upd_done_o` when the new seconds, minutes and hours each equal their alarm register. An alarm byte with bits 7:6 both set matches any value.
- R14: Ticks that arrive while an update is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| idx_we | input | 1 | Load register index from wdata[3:0] |
| data_we | input | 1 | Write wdata to the indexed register |
| wdata | input | 8 | Write data / index |
| rdata | output | 8 | Contents of the indexed register |
| uip_o | output | 1 | Update-in-progress flag |
| upd_done_o | output | 1 | One-cycle update-ended pulse |
| alarm_o | output | 1 | One-cycle alarm match pulse |

## Verification
Every value of seconds, minutes and 24-hour hours is stepped once in BCD and once in binary. These sweeps tell apart correct decimal digit carries from plain binary increments, and catch wrap points that are off by one. The 12-hour sweep walks all 24 AM/PM codes, which separates the noon and midnight flag flips from the ordinary 12→1 step. The calendar sweep puts every month at its last day and at the day before it, in a leap year, a non-leap year and year 99. This shows each month length, February in both kinds of year, and the year wrap. Separate patterns exercise the freeze bit, ticks that arrive while busy, coding changes without conversion, exact and wildcard alarm matches, and a near-miss alarm.

// File: rtl/rtc_tod_pkg.sv
package rtc_tod_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_STEP,
        ST_FINISH
    } seq_state_e;

    localparam int DATA_W    = 8;
    localparam int IDX_W     = 4;
    localparam int NUM_TOD   = 10;
    localparam int NUM_FIELD = 6;
    localparam int NUM_ALARM = 3;

    localparam int OFS_SEC   = 0;
    localparam int OFS_ASEC  = 1;
    localparam int OFS_MIN   = 2;
    localparam int OFS_AMIN  = 3;
    localparam int OFS_HOUR  = 4;
    localparam int OFS_AHOUR = 5;
    localparam int OFS_WDAY  = 6;
    localparam int OFS_DATE  = 7;
    localparam int OFS_MON   = 8;
    localparam int OFS_YEAR  = 9;
    localparam int OFS_CTLA  = 10;
    localparam int OFS_CTLB  = 11;
    localparam int OFS_CTLC  = 12;
    localparam int OFS_CTLD  = 13;

    localparam int CB_FREEZE = 7;
    localparam int CB_BIN    = 2;
    localparam int CB_H24    = 1;

    localparam logic [DATA_W-1:0] CTLB_RESET = 8'h02;
    localparam logic [DATA_W-1:0] CTLD_VALUE = 8'h80;

    // Stored code to plain number.
    function automatic logic [7:0] code_to_num(input logic [7:0] c, input logic bin);
        logic [7:0] tens;
        tens = {4'd0, c[7:4]};
        return bin ? c : (tens * 8'd10 + {4'd0, c[3:0]});
    endfunction

    // Plain number (0-99) to stored code.
    function automatic logic [7:0] num_to_code(input logic [7:0] n, input logic bin);
        logic [7:0] t;
        logic [7:0] o;
        t = n / 8'd10;
        o = n % 8'd10;
        return bin ? n : {t[3:0], o[3:0]};
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
        logic [7:0] d;
        case (mon)
            8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
            8'd2:                    d = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            default:                 d = 8'd31;
        endcase
        return d;
    endfunction

    // Which register each generic counting field drives.
    function automatic int field_reg(input int i);
        case (i)
            0:       return OFS_SEC;
            1:       return OFS_MIN;
            2:       return OFS_WDAY;
            3:       return OFS_DATE;
            4:       return OFS_MON;
            default: return OFS_YEAR;
        endcase
    endfunction

    function automatic logic [7:0] field_lo(input int i);
        return (i == 2 || i == 3 || i == 4) ? 8'd1 : 8'd0;
    endfunction

    function automatic logic [7:0] tod_reset(input int i);
        return (i == OFS_WDAY || i == OFS_DATE || i == OFS_MON) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/rtc_tod_seq.sv
module rtc_tod_seq
    import rtc_tod_pkg::*;
#(
    parameter int LEAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic uip,
    output logic step_en,
    output logic done
);

    localparam int CW = (LEAD > 1) ? $clog2(LEAD) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(LEAD - 1);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && !freeze)     state_d = ST_ARMED;
            ST_ARMED:  if (cnt_q == CNT_LAST)   state_d = ST_STEP;
            ST_STEP:   state_d = freeze ? ST_IDLE : ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // State register and lead counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_ARMED) ? cnt_q + 1'b1 : '0;
        end
    end

    // Outputs.
    always_comb begin
        uip     = 1'b0;
        step_en = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ARMED:  uip = 1'b1;
            ST_STEP: begin
                uip     = 1'b1;
                step_en = !freeze;
            end
            ST_FINISH: done = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtc_tod_field.sv
module rtc_tod_field
    import rtc_tod_pkg::*;
#(
    parameter logic [7:0] LO = 8'd0
) (
    input  logic [7:0] cur,
    input  logic       bin_mode,
    input  logic       carry_in,
    input  logic [7:0] hi,
    output logic [7:0] nxt,
    output logic       carry_out
);

    logic [7:0] num;

    always_comb begin
        num       = code_to_num(cur, bin_mode);
        carry_out = carry_in && (num >= hi);
        if (!carry_in) begin
            nxt = cur;
        end else if (num >= hi) begin
            nxt = num_to_code(LO, bin_mode);
        end else begin
            nxt = num_to_code(num + 8'd1, bin_mode);
        end
    end

endmodule

// File: rtl/rtc_tod_hour.sv
module rtc_tod_hour
    import rtc_tod_pkg::*;
(
    input  logic [7:0] cur,
    input  logic       bin_mode,
    input  logic       h24,
    input  logic       carry_in,
    output logic [7:0] nxt,
    output logic       carry_out
);

    logic       pm;
    logic [7:0] num24;
    logic [7:0] num12;

    always_comb begin
        pm        = cur[7];
        num24     = code_to_num(cur, bin_mode);
        num12     = code_to_num({1'b0, cur[6:0]}, bin_mode);
        nxt       = cur;
        carry_out = 1'b0;
        if (carry_in) begin
            if (h24) begin
                if (num24 >= 8'd23) begin
                    nxt       = num_to_code(8'd0, bin_mode);
                    carry_out = 1'b1;
                end else begin
                    nxt = num_to_code(num24 + 8'd1, bin_mode);
                end
            end else if (num12 == 8'd11) begin
                nxt       = num_to_code(8'd12, bin_mode) | {!pm, 7'd0};
                carry_out = pm;
            end else if (num12 >= 8'd12) begin
                nxt = num_to_code(8'd1, bin_mode) | {pm, 7'd0};
            end else begin
                nxt = num_to_code(num12 + 8'd1, bin_mode) | {pm, 7'd0};
            end
        end
    end

endmodule

// File: rtl/rtc_tod_alarm.sv
module rtc_tod_alarm
    import rtc_tod_pkg::*;
#(
    parameter int N = NUM_ALARM
) (
    input  logic [7:0] cur [N],
    input  logic [7:0] alm [N],
    output logic       match
);

    logic [N-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hit[g] = (alm[g][7:6] == 2'b11) || (alm[g] == cur[g]);
        end
    endgenerate

    assign match = &hit;

endmodule

// File: rtl/rtc_tod_core.sv
module rtc_tod_core
    import rtc_tod_pkg::*;
#(
    parameter int UIP_LEAD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       idx_we,
    input  logic       data_we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       uip_o,
    output logic       upd_done_o,
    output logic       alarm_o
);

    logic [IDX_W-1:0]  ptr_q;
    logic [DATA_W-1:0] tod_q   [NUM_TOD];
    logic [DATA_W-1:0] tod_nxt [NUM_TOD];
    logic [6:0]        ctla_q;
    logic [DATA_W-1:0] ctlb_q;

    logic bin_mode, h24, freeze;
    logic step_en, seq_done, match;

    assign bin_mode = ctlb_q[CB_BIN];
    assign h24      = ctlb_q[CB_H24];
    assign freeze   = ctlb_q[CB_FREEZE];

    rtc_tod_seq #(.LEAD(UIP_LEAD)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .freeze  (freeze),
        .uip     (uip_o),
        .step_en (step_en),
        .done    (seq_done)
    );

    // Counting chain.
    logic       f_cin  [NUM_FIELD];
    logic       f_cout [NUM_FIELD];
    logic [7:0] f_hi   [NUM_FIELD];
    logic [7:0] f_nxt  [NUM_FIELD];
    logic [7:0] hr_nxt;
    logic       hr_cout;
    logic       unused_carries;

    always_comb begin
        f_hi[0] = 8'd59;
        f_hi[1] = 8'd59;
        f_hi[2] = 8'd7;
        f_hi[3] = month_days(code_to_num(tod_q[OFS_MON], bin_mode),
                             code_to_num(tod_q[OFS_YEAR], bin_mode));
        f_hi[4] = 8'd12;
        f_hi[5] = 8'd99;
        f_cin[0] = step_en;
        f_cin[1] = f_cout[0];
        f_cin[2] = hr_cout;
        f_cin[3] = hr_cout;
        f_cin[4] = f_cout[3];
        f_cin[5] = f_cout[4];
    end

    assign unused_carries = f_cout[2] ^ f_cout[5];

    genvar g;
    generate
        for (g = 0; g < NUM_FIELD; g++) begin : g_fld
            rtc_tod_field #(.LO(field_lo(g))) u_fld (
                .cur       (tod_q[field_reg(g)]),
                .bin_mode  (bin_mode),
                .carry_in  (f_cin[g]),
                .hi        (f_hi[g]),
                .nxt       (f_nxt[g]),
                .carry_out (f_cout[g])
            );
        end
    endgenerate

    rtc_tod_hour u_hour (
        .cur       (tod_q[OFS_HOUR]),
        .bin_mode  (bin_mode),
        .h24       (h24),
        .carry_in  (f_cout[1]),
        .nxt       (hr_nxt),
        .carry_out (hr_cout)
    );

    always_comb begin
        for (int i = 0; i < NUM_TOD; i++) tod_nxt[i] = tod_q[i];
        for (int k = 0; k < NUM_FIELD; k++) tod_nxt[field_reg(k)] = f_nxt[k];
        tod_nxt[OFS_HOUR] = hr_nxt;
    end

    // Register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            ctla_q <= '0;
            ctlb_q <= CTLB_RESET;
            for (int i = 0; i < NUM_TOD; i++) tod_q[i] <= tod_reset(i);
        end else begin
            if (idx_we) ptr_q <= wdata[IDX_W-1:0];
            for (int i = 0; i < NUM_TOD; i++) begin
                if (data_we && ptr_q == IDX_W'(i)) tod_q[i] <= wdata;
                else if (step_en)                  tod_q[i] <= tod_nxt[i];
            end
            if (data_we && ptr_q == IDX_W'(OFS_CTLA)) ctla_q <= wdata[6:0];
            if (data_we && ptr_q == IDX_W'(OFS_CTLB)) ctlb_q <= wdata;
        end
    end

    // Alarm compare on the freshly updated time.
    logic [7:0] alm_cur [NUM_ALARM];
    logic [7:0] alm_ref [NUM_ALARM];

    assign alm_cur[0] = tod_q[OFS_SEC];
    assign alm_cur[1] = tod_q[OFS_MIN];
    assign alm_cur[2] = tod_q[OFS_HOUR];
    assign alm_ref[0] = tod_q[OFS_ASEC];
    assign alm_ref[1] = tod_q[OFS_AMIN];
    assign alm_ref[2] = tod_q[OFS_AHOUR];

    rtc_tod_alarm #(.N(NUM_ALARM)) u_alarm (
        .cur   (alm_cur),
        .alm   (alm_ref),
        .match (match)
    );

    assign upd_done_o = seq_done;
    assign alarm_o    = seq_done && match;

    // Read mux.
    always_comb begin
        case (ptr_q)
            4'd0:  rdata = tod_q[0];
            4'd1:  rdata = tod_q[1];
            4'd2:  rdata = tod_q[2];
            4'd3:  rdata = tod_q[3];
            4'd4:  rdata = tod_q[4];
            4'd5:  rdata = tod_q[5];
            4'd6:  rdata = tod_q[6];
            4'd7:  rdata = tod_q[7];
            4'd8:  rdata = tod_q[8];
            4'd9:  rdata = tod_q[9];
            4'd10: rdata = {uip_o, ctla_q};
            4'd11: rdata = ctlb_q;
            4'd13: rdata = CTLD_VALUE;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_tod_chk.sv
module rtc_tod_chk #(
    parameter int LEAD = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       uip,
    input logic       done,
    input logic       alarm,
    input logic       set_bit,
    input logic       data_we,
    input logic [7:0] sec_q
);

    int run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 0;
        else        run_q <= uip ? run_q + 1 : 0;
    end

    // R3
    uip_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uip |-> (run_q <= LEAD));

    // R14
    uip_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> ($past(tick) && !$past(set_bit)));

    // R4
    done_at_uip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(uip));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    alarm_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> done);

    // R10
    frozen_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_bit) && !$past(data_we)) |-> $stable(sec_q));

    // R10
    frozen_no_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && set_bit && !uip) |=> !uip);

endmodule

bind rtc_tod_core rtc_tod_chk #(.LEAD(UIP_LEAD)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1hz),
    .uip     (uip_o),
    .done    (upd_done_o),
    .alarm   (alarm_o),
    .set_bit (ctlb_q[7]),
    .data_we (data_we),
    .sec_q   (tod_q[0])
);

// File: tb/sim_rtc_tod_core.sv
`timescale 1ns/1ps
module sim_rtc_tod_core;

    localparam int LEAD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       idx_we = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       uip_o, upd_done_o, alarm_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rtc_tod_core #(.UIP_LEAD(LEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .idx_we(idx_we),
        .data_we(data_we), .wdata(wdata), .rdata(rdata), .uip_o(uip_o),
        .upd_done_o(upd_done_o), .alarm_o(alarm_o)
    );

    function automatic int enc(int n, bit bin);
        return bin ? n : ((n / 10) * 16 + (n % 10));
    endfunction

    function automatic int dim(int m, int y);
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        return 31;
    endfunction

    function automatic int h12(int k, bit bin);
        int hh;
        hh = (k % 12 == 0) ? 12 : k % 12;
        return enc(hh, bin) + ((k >= 12) ? 128 : 0);
    endfunction

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(int idx, int val);
        @(negedge clk); idx_we = 1'b1; wdata = 8'(idx);
        @(negedge clk); idx_we = 1'b0; data_we = 1'b1; wdata = 8'(val);
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic rd_chk(string req, int idx, int exp);
        @(negedge clk); idx_we = 1'b1; wdata = 8'(idx);
        @(negedge clk); idx_we = 1'b0;
        check(req, int'(rdata), exp);
    endtask

    task automatic cfg(bit bin, bit h24, bit frz);
        wr(11, (frz ? 128 : 0) + (bin ? 4 : 0) + (h24 ? 2 : 0));
    endtask

    task automatic do_tick(output bit dn, output bit al);
        int len;
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        len = 0;
        while (uip_o && len < 100) begin
            len++;
            @(negedge clk);
        end
        check("R3 uip window length", len, LEAD + 1);
        dn = upd_done_o;
        al = alarm_o;
        check("R4 done at uip fall", int'(dn), 1);
        @(negedge clk);
        check("R4 done one cycle", int'(upd_done_o), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL R3 watchdog: got=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit dn, al;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state, R11 fixed registers
        for (int i = 0; i < 10; i++)
            rd_chk("R2 reset time regs", i, (i >= 6 && i <= 8) ? 1 : 0);
        rd_chk("R2 reset ctl A", 10, 0);
        rd_chk("R2 reset ctl B", 11, 2);
        rd_chk("R11 ctl C", 12, 0);
        rd_chk("R11 ctl D", 13, 8'h80);
        rd_chk("R11 index 14", 14, 0);
        check("R2 reset outputs", {uip_o, upd_done_o, alarm_o}, 0);

        // R1 access
        wr(1, 8'h5A); wr(3, 8'hA5); wr(5, 8'h3C);
        rd_chk("R1 alarm sec", 1, 8'h5A);
        rd_chk("R1 alarm min", 3, 8'hA5);
        rd_chk("R1 alarm hour", 5, 8'h3C);
        wr(1, 0); wr(3, 0); wr(5, 0);

        // R11 read-only status bit
        wr(10, 8'hFF);
        rd_chk("R11 ctl A bit7 ignored", 10, 8'h7F);
        wr(13, 8'h00);
        rd_chk("R11 ctl D write ignored", 13, 8'h80);

        // R5 R8 seconds sweep
        for (int b = 0; b < 2; b++) begin
            cfg(b[0], 1'b1, 1'b0);
            for (int s = 0; s < 60; s++) begin
                wr(0, enc(s, b[0])); wr(2, enc(10, b[0]));
                do_tick(dn, al);
                rd_chk("R5 R8 sec step", 0, enc((s + 1) % 60, b[0]));
                rd_chk("R5 sec carry", 2, enc((s == 59) ? 11 : 10, b[0]));
            end
        end

        // R5 minutes sweep
        for (int b = 0; b < 2; b++) begin
            cfg(b[0], 1'b1, 1'b0);
            for (int m = 0; m < 60; m++) begin
                wr(0, enc(59, b[0])); wr(2, enc(m, b[0])); wr(4, enc(5, b[0]));
                do_tick(dn, al);
                rd_chk("R5 min step", 2, enc((m + 1) % 60, b[0]));
                rd_chk("R5 min carry", 4, enc((m == 59) ? 6 : 5, b[0]));
            end
        end

        // R6 24-hour sweep
        for (int b = 0; b < 2; b++) begin
            cfg(b[0], 1'b1, 1'b0);
            for (int h = 0; h < 24; h++) begin
                wr(0, enc(59, b[0])); wr(2, enc(59, b[0])); wr(4, enc(h, b[0]));
                wr(6, 3); wr(7, enc(10, b[0])); wr(8, 5);
                do_tick(dn, al);
                rd_chk("R6 hour step", 4, enc((h + 1) % 24, b[0]));
                rd_chk("R6 date carry", 7, enc((h == 23) ? 11 : 10, b[0]));
                rd_chk("R9 weekday carry", 6, (h == 23) ? 4 : 3);
            end
        end

        // R7 12-hour sweep
        for (int b = 0; b < 2; b++) begin
            cfg(b[0], 1'b0, 1'b0);
            for (int k = 0; k < 24; k++) begin
                wr(0, enc(59, b[0])); wr(2, enc(59, b[0])); wr(4, h12(k, b[0]));
                wr(7, enc(10, b[0])); wr(8, 5);
                do_tick(dn, al);
                rd_chk("R7 12h step", 4, h12((k + 1) % 24, b[0]));
                rd_chk("R7 12h date carry", 7, enc((k == 23) ? 11 : 10, b[0]));
            end
        end

        // R9 calendar sweep
        for (int b = 0; b < 2; b++) begin
            cfg(b[0], 1'b1, 1'b0);
            for (int yi = 0; yi < 3; yi++) begin
                int yr;
                yr = (yi == 0) ? 2 : (yi == 1) ? 4 : 99;
                for (int mo = 1; mo <= 12; mo++) begin
                    int d;
                    d = dim(mo, yr);
                    wr(0, enc(59, b[0])); wr(2, enc(59, b[0])); wr(4, enc(23, b[0]));
                    wr(6, 7); wr(7, enc(d, b[0])); wr(8, enc(mo, b[0])); wr(9, enc(yr, b[0]));
                    do_tick(dn, al);
                    rd_chk("R9 date wrap", 7, 1);
                    rd_chk("R9 weekday wrap", 6, 1);
                    rd_chk("R9 month step", 8, enc((mo == 12) ? 1 : mo + 1, b[0]));
                    rd_chk("R9 year step", 9, enc((mo == 12) ? (yr + 1) % 100 : yr, b[0]));
                    wr(0, enc(59, b[0])); wr(2, enc(59, b[0])); wr(4, enc(23, b[0]));
                    wr(7, enc(d - 1, b[0])); wr(8, enc(mo, b[0])); wr(9, enc(yr, b[0]));
                    do_tick(dn, al);
                    rd_chk("R9 date no wrap", 7, enc(d, b[0]));
                    rd_chk("R9 month hold", 8, enc(mo, b[0]));
                end
            end
        end

        // R10 freeze
        cfg(1'b0, 1'b1, 1'b1);
        wr(0, 8'h33);
        begin
            int highs;
            highs = 0;
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
            for (int i = 0; i < LEAD + 4; i++) begin
                if (uip_o || upd_done_o) highs++;
                @(negedge clk);
            end
            check("R10 no update while frozen", highs, 0);
        end
        rd_chk("R10 write while frozen kept", 0, 8'h33);
        cfg(1'b0, 1'b1, 1'b0);
        do_tick(dn, al);
        rd_chk("R10 counts after unfreeze", 0, 8'h34);

        // R14 tick during busy
        wr(0, 8'h05);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (LEAD + 4) @(negedge clk);
        check("R14 no second window", int'(uip_o), 0);
        rd_chk("R14 single increment", 0, 8'h06);

        // R12 no conversion on mode change
        cfg(1'b0, 1'b1, 1'b0);
        wr(0, 8'h25); wr(4, 8'h15);
        cfg(1'b1, 1'b1, 1'b0);
        rd_chk("R12 sec unchanged by coding", 0, 8'h25);
        cfg(1'b1, 1'b0, 1'b0);
        rd_chk("R12 hour unchanged by format", 4, 8'h15);

        // R13 alarm
        cfg(1'b0, 1'b1, 1'b0);
        wr(4, 8'h10); wr(2, 8'h20); wr(0, 8'h29);
        wr(1, 8'h30); wr(3, 8'h20); wr(5, 8'h10);
        do_tick(dn, al);
        check("R13 exact alarm match", int'(al), 1);
        wr(1, 8'h32);
        do_tick(dn, al);
        check("R13 near miss no alarm", int'(al), 0);
        wr(1, 8'hC0); wr(3, 8'hC0); wr(5, 8'hC0);
        do_tick(dn, al);
        check("R13 full wildcard", int'(al), 1);
        wr(1, 8'h40);
        do_tick(dn, al);
        check("R13 wildcard with sec miss", int'(al), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule